// File: doc/BRIEF.md
# Interrupt Acceptance and Preemption Unit

This unit sits beside a processor core and decides, once per clock, whether an interrupt is taken. It looks at a nonmaskable request line and at one maskable request from an outside controller. The maskable request carries a priority level and the number of the register set its handler should run in. The decision uses a small status word that software can write and hardware updates. The status word holds a global interrupt enable and an enable for interrupts that target the register set already running. The core supplies the register set and the level it is currently executing at.

When a request wins, the unit emits a one-cycle take pulse together with the register set and level to switch to. At the same edge it copies the status word into a saved-status register and clears the global enable, so that any nesting is left to handler software. A nonmaskable interrupt always goes to its own dedicated register set and raises a sticky mode flag. That flag drops when software re-enables maskable interrupts and one of them preempts the handler, or when an exception-return command restores the saved status.

Top module: `irq_accept_unit`

## Requirements
- R1: While status bit 0 (global enable) is 0, a maskable request never produces a take pulse.
- R2: Taking a maskable interrupt copies the status word into the saved register and clears status bit 0, visible together with the take pulse.
- R3: A maskable request whose target set differs from `cur_rset` is taken when bit 0 is 1 and its level is strictly greater than `cur_level`; status bit 1 has no effect on it. An equal level is not taken.
- R4: A maskable request whose target set equals `cur_rset` is taken only if its level is strictly greater than `cur_level` and status bit 1 (same-set enable) is 1.
- R5: A rising edge on `nmi_req` is taken whatever the status bits. The take shows `take_rset` equal to `NMI_RS` (7 by default) and `take_level` equal to `cur_level`; it sets `nmi_mode`, clears status bit 0 and saves the prior status.
- R6: While `nmi_mode` is 1, further rising edges on `nmi_req` are dropped, and maskable requests stay blocked while bit 0 is 0.
- R7: If software sets bit 0 while `nmi_mode` is 1, a later qualifying maskable request is taken and clears `nmi_mode`.
- R8: When a nonmaskable edge and a qualifying maskable request arrive in the same cycle, the nonmaskable one is taken and the maskable one is not.
- R9: `take_irq` is high for exactly one cycle and shows decisions made at the previous clock edge. No entry is accepted in the cycle right after an entry; a nonmaskable edge seen in that cycle is held and taken one cycle later.
- R10: An `eret` pulse restores the status word from the saved register in one cycle and clears `nmi_mode`.
- R11: In a given cycle an interrupt entry takes precedence over `eret`, and `eret` takes precedence over a software status write; the losing write is dropped.
- R12: After reset, `take_irq`, `nmi_mode`, `status`, `take_rset` and `take_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Nonmaskable request; its rising edge requests entry |
| mreq_valid | input | 1 | A maskable request is pending |
| mreq_level | input | LVL_W | Level of the maskable request |
| mreq_rset | input | RS_W | Register set for the maskable handler |
| cur_rset | input | RS_W | Register set now executing |
| cur_level | input | LVL_W | Level now executing |
| sw_we | input | 1 | Software writes the status word |
| sw_status | input | 2 | Value written: bit 0 global enable, bit 1 same-set enable |
| eret | input | 1 | Exception return: restore saved status |
| take_irq | output | 1 | One-cycle interrupt entry pulse |
| take_rset | output | RS_W | Register set to switch to on entry |
| take_level | output | LVL_W | Level to run at after entry |
| nmi_mode | output | 1 | Nonmaskable handler active |
| status | output | 2 | Current status word |

## Verification
The bench pushes a maskable request at exactly the current level, both to the running set and to another set. A design that used greater-or-equal, or that applied the same-set enable to every set, would take one of these. It lines up a nonmaskable edge with a maskable request and places another edge in the cycle right after an entry. A wrong design would take the maskable request, drop the held edge, or issue two back-to-back pulses. It also tests preemption out of the nonmaskable handler once software re-enables interrupts, return from an exception while in that mode, and a software write or `eret` that collides with an entry. A wrong design would leave the mode flag stuck, fail to restore the saved word, or let a colliding write overwrite the hardware update.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int STAT_W = 2;

  // Status word: bit 0 global enable, bit 1 same-set enable.
  typedef struct packed {
    logic rsie;
    logic gie;
  } stat_t;

  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_MASK = 2'd1,
    ENT_NMI  = 2'd2
  } entry_e;

endpackage

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic nmi_mode,
  input  logic nmi_taken,
  output logic nmi_want
);

  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = nmi_req & ~prev_q;

  always_comb begin
    prev_d = nmi_req;
    pend_d = pend_q;
    if (nmi_taken) begin
      pend_d = 1'b0;
    end else if (rise && !nmi_mode) begin
      pend_d = 1'b1;
    end
  end

  // A held edge or a fresh edge outside NMI mode asks for entry.
  assign nmi_want = pend_q | (rise & ~nmi_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/irq_accept_arbiter.sv
module irq_accept_arbiter
  import irq_accept_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int RS_W  = 3
) (
  input  logic             nmi_want,
  input  logic             block,
  input  stat_t            stat,
  input  logic             mreq_valid,
  input  logic [LVL_W-1:0] mreq_level,
  input  logic [RS_W-1:0]  mreq_rset,
  input  logic [RS_W-1:0]  cur_rset,
  input  logic [LVL_W-1:0] cur_level,
  output entry_e           kind
);

  logic same_set;
  logic lvl_above;
  logic set_ok;
  logic nmi_ok;
  logic mask_ok;

  assign same_set  = (mreq_rset == cur_rset);
  assign lvl_above = (mreq_level > cur_level);
  // The same-set enable gates only requests aimed at the running set.
  assign set_ok    = same_set ? stat.rsie : 1'b1;

  assign nmi_ok  = nmi_want & ~block;
  assign mask_ok = mreq_valid & stat.gie & ~block & lvl_above & set_ok;

  always_comb begin
    if (nmi_ok) begin
      kind = ENT_NMI;
    end else if (mask_ok) begin
      kind = ENT_MASK;
    end else begin
      kind = ENT_NONE;
    end
  end

endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_accept_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  entry_e kind,
  input  logic   eret,
  input  logic   sw_we,
  input  stat_t  sw_stat,
  output stat_t  stat_q,
  output stat_t  saved_q,
  output logic   nmi_mode_q
);

  stat_t stat_d, saved_d;
  logic  mode_d;
  logic  ctx_en;

  assign ctx_en = (kind != ENT_NONE) | eret | sw_we;

  always_comb begin
    stat_d  = stat_q;
    saved_d = saved_q;
    mode_d  = nmi_mode_q;
    unique case (kind)
      ENT_NMI: begin
        saved_d    = stat_q;
        stat_d.gie = 1'b0;
        mode_d     = 1'b1;
      end
      ENT_MASK: begin
        saved_d    = stat_q;
        stat_d.gie = 1'b0;
        mode_d     = 1'b0;
      end
      default: begin
        if (eret) begin
          stat_d = saved_q;
          mode_d = 1'b0;
        end else if (sw_we) begin
          stat_d = sw_stat;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= '0;
      saved_q    <= '0;
      nmi_mode_q <= 1'b0;
    end else if (ctx_en) begin
      stat_q     <= stat_d;
      saved_q    <= saved_d;
      nmi_mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/irq_take_out.sv
module irq_take_out
  import irq_accept_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int RS_W   = 3,
  parameter int NMI_RS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  entry_e           kind,
  input  logic [LVL_W-1:0] mreq_level,
  input  logic [RS_W-1:0]  mreq_rset,
  input  logic [LVL_W-1:0] cur_level,
  output logic             take_q,
  output logic [RS_W-1:0]  rset_q,
  output logic [LVL_W-1:0] level_q
);

  localparam logic [RS_W-1:0] NMI_SET = RS_W'(NMI_RS);

  logic             take_d;
  logic             load_en;
  logic [RS_W-1:0]  rset_d;
  logic [LVL_W-1:0] level_d;

  assign take_d  = (kind != ENT_NONE);
  assign load_en = take_d;

  always_comb begin
    rset_d  = rset_q;
    level_d = level_q;
    if (kind == ENT_NMI) begin
      rset_d  = NMI_SET;
      level_d = cur_level;
    end else if (kind == ENT_MASK) begin
      rset_d  = mreq_rset;
      level_d = mreq_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
    end else begin
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rset_q  <= '0;
      level_q <= '0;
    end else if (load_en) begin
      rset_q  <= rset_d;
      level_q <= level_d;
    end
  end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int RS_W   = 3,
  parameter int NMI_RS = (1 << RS_W) - 1,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req,
  input  logic              mreq_valid,
  input  logic [LVL_W-1:0]  mreq_level,
  input  logic [RS_W-1:0]   mreq_rset,
  input  logic [RS_W-1:0]   cur_rset,
  input  logic [LVL_W-1:0]  cur_level,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_status,
  input  logic              eret,
  output logic              take_irq,
  output logic [RS_W-1:0]   take_rset,
  output logic [LVL_W-1:0]  take_level,
  output logic              nmi_mode,
  output logic [STAT_W-1:0] status
);

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_s_n;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[SYNC_N-1];

  entry_e kind;
  stat_t  stat_q, saved_q;
  logic   nmi_want;
  logic   mode_q;
  logic   take_q;

  irq_nmi_detect u_nmi (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .nmi_req   (nmi_req),
    .nmi_mode  (mode_q),
    .nmi_taken (kind == ENT_NMI),
    .nmi_want  (nmi_want)
  );

  irq_accept_arbiter #(.LVL_W(LVL_W), .RS_W(RS_W)) u_arb (
    .nmi_want   (nmi_want),
    .block      (take_q),
    .stat       (stat_q),
    .mreq_valid (mreq_valid),
    .mreq_level (mreq_level),
    .mreq_rset  (mreq_rset),
    .cur_rset   (cur_rset),
    .cur_level  (cur_level),
    .kind       (kind)
  );

  irq_ctx_regs u_ctx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .kind       (kind),
    .eret       (eret),
    .sw_we      (sw_we),
    .sw_stat    (stat_t'(sw_status)),
    .stat_q     (stat_q),
    .saved_q    (saved_q),
    .nmi_mode_q (mode_q)
  );

  irq_take_out #(.LVL_W(LVL_W), .RS_W(RS_W), .NMI_RS(NMI_RS)) u_take (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .kind       (kind),
    .mreq_level (mreq_level),
    .mreq_rset  (mreq_rset),
    .cur_level  (cur_level),
    .take_q     (take_q),
    .rset_q     (take_rset),
    .level_q    (take_level)
  );

  logic [STAT_W-1:0] saved_bits;
  logic [1:0]        kind_bits;

  assign saved_bits = saved_q;
  assign kind_bits  = kind;
  assign take_irq   = take_q;
  assign nmi_mode   = mode_q;
  assign status     = stat_q;

endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker #(
  parameter int LVL_W  = 6,
  parameter int RS_W   = 3,
  parameter int NMI_RS = 7
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             eret,
  input logic [RS_W-1:0]  cur_rset,
  input logic [LVL_W-1:0] cur_level,
  input logic             take_irq,
  input logic [RS_W-1:0]  take_rset,
  input logic [LVL_W-1:0] take_level,
  input logic             nmi_mode,
  input logic [1:0]       status,
  input logic [1:0]       saved_bits,
  input logic [1:0]       kind_bits
);

  assert_no_mask_when_off_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take_irq && !nmi_mode) |-> $past(status[0]));

  assert_entry_clears_gie_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    take_irq |-> !status[0]);

  assert_level_above_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take_irq && !nmi_mode) |-> (take_level > $past(cur_level)));

  assert_same_set_enable_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take_irq && !nmi_mode && take_rset == $past(cur_rset)) |-> $past(status[1]));

  assert_nmi_set_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(nmi_mode) |-> (take_irq && take_rset == RS_W'(NMI_RS)));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    take_irq |=> !take_irq);

  assert_eret_restore_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (eret && kind_bits == 2'd0) |=> (status == $past(saved_bits) && !nmi_mode));

endmodule

bind irq_accept_unit irq_accept_checker #(
  .LVL_W(LVL_W), .RS_W(RS_W), .NMI_RS(NMI_RS)
) u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .eret       (eret),
  .cur_rset   (cur_rset),
  .cur_level  (cur_level),
  .take_irq   (take_irq),
  .take_rset  (take_rset),
  .take_level (take_level),
  .nmi_mode   (nmi_mode),
  .status     (status),
  .saved_bits (saved_bits),
  .kind_bits  (kind_bits)
);

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;

  localparam int LVL_W = 6;
  localparam int RS_W  = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             nmi_req, mreq_valid, sw_we, eret;
  logic [LVL_W-1:0] mreq_level, cur_level;
  logic [RS_W-1:0]  mreq_rset, cur_rset;
  logic [1:0]       sw_status;
  logic             take_irq, nmi_mode;
  logic [RS_W-1:0]  take_rset;
  logic [LVL_W-1:0] take_level;
  logic [1:0]       status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_accept_unit #(.LVL_W(LVL_W), .RS_W(RS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .mreq_valid(mreq_valid),
    .mreq_level(mreq_level), .mreq_rset(mreq_rset), .cur_rset(cur_rset),
    .cur_level(cur_level), .sw_we(sw_we), .sw_status(sw_status), .eret(eret),
    .take_irq(take_irq), .take_rset(take_rset), .take_level(take_level),
    .nmi_mode(nmi_mode), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_status(input logic [1:0] v);
    sw_we = 1'b1; sw_status = v;
    tick();
    sw_we = 1'b0;
  endtask

  task automatic mreq(input logic v, input int rs, input int lv);
    mreq_valid = v; mreq_rset = RS_W'(rs); mreq_level = LVL_W'(lv);
  endtask

  task automatic t_reset();
    chk("R12 take", take_irq, 0);
    chk("R12 status", status, 0);
    chk("R12 nmi_mode", nmi_mode, 0);
    chk("R12 rset", take_rset, 0);
    chk("R12 level", take_level, 0);
  endtask

  task automatic t_gie_off();
    cur_rset = 0; cur_level = 1;
    mreq(1, 2, 5);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R1 ignored with gie=0", take_irq, 0);
    end
    mreq_valid = 0;
  endtask

  task automatic t_other_set();
    set_status(2'b01);
    mreq(1, 2, 5);
    tick();
    chk("R3 take other set", take_irq, 1);
    chk("R3 rset", take_rset, 2);
    chk("R3 level", take_level, 5);
    chk("R2 gie cleared", status, 2'b00);
    tick();
    chk("R9 pulse ends", take_irq, 0);
    mreq_valid = 0;
    set_status(2'b01);
    mreq(1, 2, 1);
    tick();
    chk("R3 equal level not taken", take_irq, 0);
    tick();
    chk("R3 equal level still not taken", take_irq, 0);
    mreq_valid = 0;
  endtask

  task automatic t_same_set();
    mreq(1, 0, 3);
    tick();
    chk("R4 same set rsie=0", take_irq, 0);
    mreq_valid = 0;
    set_status(2'b11);
    mreq(1, 0, 1);
    tick();
    chk("R4 same set equal level", take_irq, 0);
    mreq(1, 0, 3);
    tick();
    chk("R4 same set taken", take_irq, 1);
    chk("R4 rset", take_rset, 0);
    chk("R2 status after same-set take", status, 2'b10);
    mreq_valid = 0;
    eret = 1;
    tick();
    eret = 0;
    chk("R10 eret restores", status, 2'b11);
  endtask

  task automatic t_nmi();
    set_status(2'b00);
    cur_rset = 1; cur_level = 4;
    nmi_req = 1;
    tick();
    chk("R5 nmi take", take_irq, 1);
    chk("R5 nmi rset", take_rset, 7);
    chk("R5 nmi level", take_level, 4);
    chk("R5 nmi_mode", nmi_mode, 1);
    tick();
    chk("R9 nmi pulse ends", take_irq, 0);
    tick();
    chk("R5 held line no retake", take_irq, 0);
    nmi_req = 0;
    tick();
    nmi_req = 1;
    tick();
    chk("R6 edge dropped in nmi mode", take_irq, 0);
    mreq(1, 2, 9);
    tick();
    chk("R6 maskable blocked", take_irq, 0);
    nmi_req = 0;
  endtask

  task automatic t_preempt();
    set_status(2'b01);
    chk("R7 no take on write edge", take_irq, 0);
    tick();
    chk("R7 maskable preempts nmi", take_irq, 1);
    chk("R7 nmi_mode cleared", nmi_mode, 0);
    chk("R7 rset", take_rset, 2);
    mreq_valid = 0;
    tick();
  endtask

  task automatic t_simul();
    set_status(2'b01);
    cur_rset = 0; cur_level = 1;
    mreq(1, 2, 5);
    nmi_req = 1;
    tick();
    chk("R8 nmi wins", take_irq, 1);
    chk("R8 nmi rset", take_rset, 7);
    chk("R8 nmi_mode", nmi_mode, 1);
    nmi_req = 0;
    tick();
    chk("R8 maskable not taken", take_irq, 0);
    eret = 1;
    tick();
    eret = 0;
    chk("R10 status restored", status, 2'b01);
    chk("R10 nmi_mode cleared", nmi_mode, 0);
    tick();
    chk("R8 maskable taken later", take_irq, 1);
    chk("R8 maskable level", take_level, 5);
    mreq_valid = 0;
    tick();
  endtask

  task automatic t_block();
    set_status(2'b01);
    mreq(1, 2, 5);
    tick();
    chk("R9 first entry", take_irq, 1);
    mreq_valid = 0;
    nmi_req = 1;
    tick();
    chk("R9 blocked after entry", take_irq, 0);
    tick();
    chk("R9 held nmi taken", take_irq, 1);
    chk("R9 held nmi rset", take_rset, 7);
    nmi_req = 0;
    eret = 1;
    tick();
    eret = 0;
    chk("R10 nmi exit by eret", nmi_mode, 0);
  endtask

  task automatic t_priority();
    set_status(2'b01);
    mreq(1, 2, 5);
    sw_we = 1; sw_status = 2'b11;
    tick();
    sw_we = 0; mreq_valid = 0;
    chk("R11 entry beats write", status, 2'b00);
    tick();
    eret = 1; sw_we = 1; sw_status = 2'b10;
    tick();
    eret = 0; sw_we = 0;
    chk("R11 eret beats write", status, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; nmi_req = 0; mreq_valid = 0; mreq_level = 0; mreq_rset = 0;
    cur_rset = 0; cur_level = 0; sw_we = 0; sw_status = 0; eret = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_gie_off();
    t_other_set();
    t_same_set();
    t_nmi();
    t_preempt();
    t_simul();
    t_block();
    t_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule